// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Single-Shot Mode

This block produces one modulated output from a fixed base clock. A 4-bit code selects a prescaler divisor from a fixed table of non-binary values. The divided clock gives a tick. A 32-bit period word sets the waveform. Its upper half is the number of ticks in one period (N). Its lower half is the number of those ticks during which the output is at its active level (D). The active level is chosen by a polarity input. The channel runs only when both its enable input and its clock-gate input are high.

Two modes are provided. In continuous mode the waveform repeats every N ticks. In single-shot mode a start strobe launches one window of N ticks, with the output active for the first D of them. The channel then idles until the next strobe. A bypass input replaces the modulated output with the base clock itself.

A new period word is staged and takes effect at the end of the running period. A busy output reports that a staged word is still waiting.

Top module: `pscaled_pwm_chan`

## Requirements
- R1: The prescaler code selects the tick divisor as follows: 0→120, 1→180, 2→240, 3→360, 4→480, 8→1200, 9→2400, 10→3600, 11→4800, 12→7200, 15→1. While running, one tick occurs every divisor base cycles, counted from the cycle the channel starts.
- R2: In continuous mode the tick position counts 0 to N−1 and wraps to 0. The output is active while the position is below D. With N = 0 the position stays at 0.
- R3: `cfg_pol` = 1 makes the active level high and the inactive level low. `cfg_pol` = 0 inverts both levels. `pwm_out` is registered and follows its inputs with one cycle of latency.
- R4: While `cfg_bypass` is 1, `pwm_out` equals the base clock `clk`.
- R5: The channel runs only while `cfg_en` and `cfg_gate` are both 1. Otherwise the prescaler and the position counter are held at 0 and the output is at its inactive level.
- R6: A `per_wr` pulse stages `per_data` and sets `per_busy` on the next cycle. The staged word becomes active at the tick that ends the current period, or one cycle later if the channel is stopped. `per_busy` clears at that same edge. A write in that cycle keeps `per_busy` set.
- R7: In single-shot mode, a `start_stb` while the channel runs and no shot is live starts a window at position 0. The output is active for the first D ticks of the window. The window ends after N ticks, and the output then stays inactive.
- R8: A `start_stb` that arrives while a shot window is live has no effect on that window.
- R9: An unused prescaler code (5, 6, 7, 13, 14) stops the ticks and holds the output at its inactive level.
- R10: After reset, `per_busy` is 0, the period word is 0 and `pwm_out` is 0 (with bypass low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_psc | input | 4 | Prescaler code |
| cfg_en | input | 1 | Channel enable |
| cfg_gate | input | 1 | Channel clock gate |
| cfg_pol | input | 1 | Active level (1 = high) |
| cfg_bypass | input | 1 | Output the base clock instead of the waveform |
| cfg_oneshot | input | 1 | 0 = continuous, 1 = single shot |
| start_stb | input | 1 | Single-shot start strobe |
| per_wr | input | 1 | Period word write strobe |
| per_data | input | 32 | Period word: N in [31:16], D in [15:0] |
| per_busy | output | 1 | Staged period word not yet loaded |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is a period write that lands while a long prescaled period is running. It is harder still when a second write arrives in the very cycle the first one loads, or when a start strobe arrives in the middle of a live shot. The stimulus writes the period word at chosen offsets inside running periods, sweeps every prescaler code (the unused ones included) with a short N, and issues repeated strobes during and after a shot. A behavioural model of the tick count and period position is compared with `pwm_out` and `per_busy` on every cycle, so each boundary falls under a check.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 13;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
  } psc_sel_t;

  function automatic psc_sel_t psc_lookup(input logic [CODE_W-1:0] code);
    psc_sel_t r;
    r.ok = 1'b1;
    unique case (code)
      4'd0:    r.div = DIV_W'(120);
      4'd1:    r.div = DIV_W'(180);
      4'd2:    r.div = DIV_W'(240);
      4'd3:    r.div = DIV_W'(360);
      4'd4:    r.div = DIV_W'(480);
      4'd8:    r.div = DIV_W'(1200);
      4'd9:    r.div = DIV_W'(2400);
      4'd10:   r.div = DIV_W'(3600);
      4'd11:   r.div = DIV_W'(4800);
      4'd12:   r.div = DIV_W'(7200);
      4'd15:   r.div = DIV_W'(1);
      default: begin r.ok = 1'b0; r.div = DIV_W'(1); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psc_tick_gen.sv
module psc_tick_gen
  import pwm_chan_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          code_ok,
  output logic          tick
);
  psc_sel_t        sel;
  logic [DW-1:0]   cnt_q;
  logic            at_end;

  always_comb begin
    sel     = psc_lookup(code);
    code_ok = sel.ok;
    at_end  = (cnt_q == sel.div - DW'(1));
    tick    = run && sel.ok && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !sel.ok) cnt_q <= '0;
    else if (at_end)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/period_shadow.sv
module period_shadow #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [2*HW-1:0] wdata,
  input  logic          run,
  input  logic          wrap,
  output logic [HW-1:0] n_cur,
  output logic [HW-1:0] d_cur,
  output logic          busy
);
  logic [2*HW-1:0] stage_q;
  logic [2*HW-1:0] live_q;
  logic            load;

  assign load  = busy && (!run || wrap);
  assign n_cur = live_q[2*HW-1:HW];
  assign d_cur = live_q[HW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      live_q  <= '0;
      busy    <= 1'b0;
    end else begin
      if (load) begin
        live_q <= stage_q;
        busy   <= 1'b0;
      end
      if (wr) begin
        stage_q <= wdata;
        busy    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wave_core.sv
module wave_core #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          code_ok,
  input  logic          tick,
  input  logic          oneshot,
  input  logic          start,
  input  logic          pol,
  input  logic [HW-1:0] n_cur,
  input  logic [HW-1:0] d_cur,
  output logic          wrap,
  output logic          shot_live,
  output logic          wave_q
);
  logic [HW-1:0] pos_q;
  logic          seg_on;
  logic          last;
  logic          launch;
  logic          active;

  always_comb begin
    seg_on = oneshot ? shot_live : 1'b1;
    last   = ({1'b0, pos_q} + (HW+1)'(1)) >= {1'b0, n_cur};
    wrap   = tick && seg_on && last;
    launch = run && oneshot && start && !shot_live;
    active = seg_on && (pos_q < d_cur);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos_q     <= '0;
      shot_live <= 1'b0;
    end else begin
      if (!oneshot)             shot_live <= 1'b0;
      else if (launch)          shot_live <= 1'b1;
      else if (wrap)            shot_live <= 1'b0;
      if (launch || wrap)       pos_q <= '0;
      else if (tick && seg_on)  pos_q <= pos_q + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= (run && code_ok && active) ? pol : !pol;
  end
endmodule

// File: rtl/pscaled_pwm_chan.sv
module pscaled_pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int CW  = CODE_W,
  parameter int DW  = DIV_W,
  parameter int HW  = HALF_W,
  localparam int PW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_psc,
  input  logic          cfg_en,
  input  logic          cfg_gate,
  input  logic          cfg_pol,
  input  logic          cfg_bypass,
  input  logic          cfg_oneshot,
  input  logic          start_stb,
  input  logic          per_wr,
  input  logic [PW-1:0] per_data,
  output logic          per_busy,
  output logic          pwm_out
);
  logic          run;
  logic          code_ok;
  logic          pre_tick;
  logic          period_wrap;
  logic          shot_live;
  logic          wave_q;
  logic [HW-1:0] n_cur;
  logic [HW-1:0] d_cur;

  assign run = cfg_en && cfg_gate;

  psc_tick_gen #(.CW(CW), .DW(DW)) u_psc (
    .clk(clk), .rst(rst), .run(run), .code(cfg_psc),
    .code_ok(code_ok), .tick(pre_tick)
  );

  period_shadow #(.HW(HW)) u_per (
    .clk(clk), .rst(rst), .wr(per_wr), .wdata(per_data),
    .run(run), .wrap(period_wrap),
    .n_cur(n_cur), .d_cur(d_cur), .busy(per_busy)
  );

  wave_core #(.HW(HW)) u_wave (
    .clk(clk), .rst(rst), .run(run), .code_ok(code_ok), .tick(pre_tick),
    .oneshot(cfg_oneshot), .start(start_stb), .pol(cfg_pol),
    .n_cur(n_cur), .d_cur(d_cur),
    .wrap(period_wrap), .shot_live(shot_live), .wave_q(wave_q)
  );

  assign pwm_out = cfg_bypass ? clk : wave_q;
endmodule

// File: rtl/pscaled_pwm_chan_chk.sv
module pscaled_pwm_chan_chk
  import pwm_chan_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] cfg_psc,
  input logic       cfg_en,
  input logic       cfg_gate,
  input logic       cfg_pol,
  input logic       cfg_oneshot,
  input logic       per_wr,
  input logic       per_busy,
  input logic       tick,
  input logic       wrap,
  input logic       firing,
  input logic       wave
);
  logic code_used;
  assign code_used = psc_lookup(cfg_psc).ok;

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    per_wr |=> per_busy); // R6
  AST_STOPPED_LOADS: assert property (@(posedge clk) disable iff (rst)
    per_busy && !per_wr && !(cfg_en && cfg_gate) |=> !per_busy); // R6
  AST_BUSY_WAITS_END: assert property (@(posedge clk) disable iff (rst)
    per_busy && !wrap && cfg_en && cfg_gate |=> per_busy); // R6
  AST_STOPPED_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !(cfg_en && cfg_gate) |=> wave == !$past(cfg_pol)); // R5
  AST_BADCODE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !code_used |=> wave == !$past(cfg_pol)); // R9
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    tick |-> cfg_en && cfg_gate && code_used); // R1
  AST_SHOT_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    firing && cfg_oneshot && cfg_en && cfg_gate && !wrap |=> firing); // R8
endmodule

bind pscaled_pwm_chan pscaled_pwm_chan_chk u_chk (
  .clk(clk), .rst(rst), .cfg_psc(cfg_psc), .cfg_en(cfg_en), .cfg_gate(cfg_gate),
  .cfg_pol(cfg_pol), .cfg_oneshot(cfg_oneshot), .per_wr(per_wr),
  .per_busy(per_busy), .tick(pre_tick), .wrap(period_wrap),
  .firing(shot_live), .wave(wave_q)
);

// File: tb/pscaled_pwm_chan_tb.sv
module pscaled_pwm_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_psc = 4'd15;
  logic        cfg_en = 0, cfg_gate = 0, cfg_pol = 1, cfg_bypass = 0, cfg_oneshot = 0;
  logic        start_stb = 0, per_wr = 0;
  logic [31:0] per_data = '0;
  logic        per_busy, pwm_out;

  always #2 clk = ~clk;

  pscaled_pwm_chan u_dut (
    .clk(clk), .rst(rst), .cfg_psc(cfg_psc), .cfg_en(cfg_en), .cfg_gate(cfg_gate),
    .cfg_pol(cfg_pol), .cfg_bypass(cfg_bypass), .cfg_oneshot(cfg_oneshot),
    .start_stb(start_stb), .per_wr(per_wr), .per_data(per_data),
    .per_busy(per_busy), .pwm_out(pwm_out)
  );

  int    checks = 0, fails = 0, cycles = 0;
  string cur_req = "R10";
  bit    started = 0, done = 0;

  // reference model state
  int m_pc = 0, m_pos = 0, m_n = 0, m_d = 0, m_sn = 0, m_sd = 0;
  bit m_busy = 0, m_fire = 0, m_out = 0;

  function automatic int div_of(input logic [3:0] c);
    case (c)
      4'd0: return 120;   4'd1: return 180;   4'd2: return 240;
      4'd3: return 360;   4'd4: return 480;   4'd8: return 1200;
      4'd9: return 2400;  4'd10: return 3600; 4'd11: return 4800;
      4'd12: return 7200; 4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int  dv, npc, npos, nn, nd, nsn, nsd;
    bit  run, ok, tk, live, wr_end, go, nfire, nbusy, act;
    started <= 1;
    cycles++;
    if (rst) begin
      m_pc = 0; m_pos = 0; m_n = 0; m_d = 0; m_sn = 0; m_sd = 0;
      m_busy = 0; m_fire = 0; m_out = 0;
    end else begin
      dv   = div_of(cfg_psc);
      ok   = dv != 0;
      run  = cfg_en && cfg_gate;
      tk   = run && ok && (m_pc == dv - 1);
      live = cfg_oneshot ? m_fire : 1;
      wr_end = tk && live && (m_pos + 1 >= m_n);
      go   = run && cfg_oneshot && start_stb && !m_fire;
      act  = live && (m_pos < m_d);
      npc  = (!run || !ok || tk) ? 0 : m_pc + 1;
      nfire = m_fire; npos = m_pos;
      if (!run) begin nfire = 0; npos = 0; end
      else begin
        if (!cfg_oneshot) nfire = 0; else if (go) nfire = 1; else if (wr_end) nfire = 0;
        if (go || wr_end) npos = 0; else if (tk && live) npos = m_pos + 1;
      end
      nn = m_n; nd = m_d; nsn = m_sn; nsd = m_sd; nbusy = m_busy;
      if (m_busy && (!run || wr_end)) begin nn = m_sn; nd = m_sd; nbusy = 0; end
      if (per_wr) begin nsn = per_data[31:16]; nsd = per_data[15:0]; nbusy = 1; end
      m_out = (run && ok && act) ? cfg_pol : !cfg_pol;
      m_pc = npc; m_pos = npos; m_fire = nfire; m_n = nn; m_d = nd;
      m_sn = nsn; m_sd = nsd; m_busy = nbusy;
    end
    #1;
    if (!done) begin
      checks++;
      if (pwm_out !== (cfg_bypass ? 1'b1 : m_out)) begin
        fails++;
        $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", cur_req, pwm_out,
                 cfg_bypass ? 1'b1 : m_out, $time);
      end
      checks++;
      if (per_busy !== m_busy) begin
        fails++;
        $display("FAIL %s per_busy actual=%b expected=%b t=%0t", cur_req, per_busy, m_busy, $time);
      end
    end
  end

  // low-phase check of the clock pass-through (R4)
  always @(negedge clk) begin
    #1;
    if (started && !done && !rst && cfg_bypass) begin
      checks++;
      if (pwm_out !== 1'b0) begin
        fails++;
        $display("FAIL R4 pwm_out low phase actual=%b expected=0", pwm_out);
      end
    end
  end

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr_per(input int n, input int d);
    @(negedge clk); per_wr = 1; per_data = {n[15:0], d[15:0]};
    @(negedge clk); per_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 190000 && !done) begin
    fails++;
    $display("FAIL watchdog expired actual=%0d cycles expected<190000", cycles);
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    cur_req = "R10"; step(2);
    cur_req = "R6";  wr_per(5, 2); step(3);            // stopped: loads one cycle later
    cur_req = "R2";  cfg_en = 1; cfg_gate = 1; step(30);
    cur_req = "R3";  cfg_pol = 0; step(20); cfg_pol = 1;
    cur_req = "R6";  step(2); wr_per(3, 3); step(12);  // load waits for period end
    wr_per(7, 4); step(4); wr_per(7, 1); step(20);      // rewrite while pending
    cur_req = "R2";  wr_per(0, 0); step(10); wr_per(4, 6); step(12);
    cur_req = "R1";  wr_per(2, 1);
    for (int c = 0; c < 16; c++) begin
      cfg_psc = c[3:0];
      cur_req = (div_of(c[3:0]) == 0) ? "R9" : "R1";
      step(2 * (div_of(c[3:0]) + 1) + 12);
    end
    cfg_psc = 4'd0; cur_req = "R6"; step(50); wr_per(3, 1); step(500);
    cfg_psc = 4'd15;
    cur_req = "R5";  cfg_gate = 0; step(10); cfg_gate = 1; cfg_en = 0; step(6); cfg_en = 1;
    wr_per(4, 2); step(10);
    cur_req = "R4";  cfg_bypass = 1; step(12); cfg_bypass = 0; step(4);
    cur_req = "R7";  wr_per(6, 3); cfg_oneshot = 1; step(10);
    @(negedge clk); start_stb = 1; @(negedge clk); start_stb = 0; step(12);
    cur_req = "R8";
    @(negedge clk); start_stb = 1; @(negedge clk); start_stb = 0; step(2);
    @(negedge clk); start_stb = 1; @(negedge clk); start_stb = 0; step(12);
    cur_req = "R7"; cfg_psc = 4'd0;
    @(negedge clk); start_stb = 1; @(negedge clk); start_stb = 0; step(900);
    cur_req = "R6"; wr_per(2, 2); step(400);
    cfg_oneshot = 0; cfg_psc = 4'd15; cur_req = "R2"; step(20);
    finish_run();
  end
endmodule